// File: doc/BRIEF.md
# I2C/SMBus Serial Clock Timing Generator

This block paces the serial clock of an I2C/SMBus master. It counts enable strobes from one of two tick sources, which are an oscillator-derived tick and a fixed-rate tick. An optional divide-by-two stage can sit in front of the count. From these ticks it builds an asymmetric clock period: the line is released for `HIGH_TICKS` effective ticks and pulled low for `LOW_TICKS` effective ticks. With the default values of 96 and 144, the bit rate is the tick rate divided by 240. The clock output is an open-drain pull-down request. A one-cycle strobe marks each falling edge and each rising edge so that a shift engine can align to them.

The block samples the wired clock line so that it can follow a slave that stretches the clock. After the block releases the line, it waits for the line to read high before it counts the high phase as started. The high window is timed from the release. When an oscillator-derived source is active, the line must also stay high for at least `MIN_HIGH_TICKS` effective ticks after it is first seen high, so a long stretch cannot squeeze the high phase to nothing. A new source selection or divider setting is taken only at the start of a low phase, so no phase is cut short. A held software-reset input keeps the whole block in its initial state until it returns to 0.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_drive_low` is 0, `running` is 0 and neither strobe is asserted.
- R2: While `src_sel` is 2'b00 and the block is idle, no strobe is produced, `scl_drive_low` stays 0 and `running` stays 0.
- R3: With `src_sel` = 2'b11, the low phase covers exactly `LOW_TICKS` `fix_tick` strobes. The high window, counted from the release of the line, covers exactly `HIGH_TICKS` `fix_tick` strobes. The block counts a tick in the cycle that the tick input is high.
- R4: With `src_sel` = 2'b01 or 2'b10, the same phase counts apply to `osc_tick` strobes instead.
- R5: With `div2_en` = 1, only every second selected tick counts, so each phase in steady state covers twice as many source strobes. The divider is cleared by reset, so the first low phase after a reset covers exactly 2×`LOW_TICKS` source strobes.
- R6: While the line reads low after release, the block does not assert `scl_rise_stb`, and it keeps running for any length of time. A stretch that ends inside the high window does not lengthen that window, which is still counted from the release.
- R7: With an oscillator-derived source active, the high phase lasts at least `MIN_HIGH_TICKS` effective ticks counted from the cycle of `scl_rise_stb`. With the fixed source there is no minimum: if the window has already run out, the falling edge follows in the cycle after `scl_rise_stb`.
- R8: Changes to `src_sel` or `div2_en` take effect only at the start of the next low phase. When `src_sel` is 2'b00 at that point, the block completes the high phase and then goes idle with the line released.
- R9: `scl_fall_stb` is high for one cycle, in the first cycle that `scl_drive_low` is 1. `scl_rise_stb` is high for one cycle, in the cycle after the line is first sampled high following a release.
- R10: While `soft_rst` is 1, the block returns to its initial state one cycle after the input is seen and stays there. In the cycle after `soft_rst` returns to 0 with a non-zero `src_sel`, the block starts a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Held software reset; the block stays in its initial state while this is 1 |
| src_sel | input | 2 | Tick source: 00 off, 01/10 oscillator tick, 11 fixed tick |
| div2_en | input | 1 | Count every second selected tick |
| osc_tick | input | 1 | Oscillator-derived enable strobe |
| fix_tick | input | 1 | Fixed-rate enable strobe |
| scl_in | input | 1 | Sampled wired clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| scl_fall_stb | output | 1 | One-cycle strobe at each falling edge |
| scl_rise_stb | output | 1 | One-cycle strobe when the released line is seen high |
| running | output | 1 | Block is producing clock periods |

## Verification
The bench builds the block with `LOW_TICKS` = 9, `HIGH_TICKS` = 6 and `MIN_HIGH_TICKS` = 3. With these values a full period takes about 60 clock cycles, so many periods, divider settings and source changes fit into a short run. The small window also lets a stretch outlast the whole high window, which reaches the minimum-high rule for the oscillator source and the no-minimum case for the fixed source. The bench counts tick strobes of the chosen source per phase and compares the counts with the programmed values.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Any non-zero select turns the generator on.
  function automatic logic sel_enabled(input logic [1:0] sel);
    return sel != 2'b00;
  endfunction

  // Codes 01 and 10 pick the oscillator-derived tick.
  function automatic logic sel_is_osc(input logic [1:0] sel);
    return (sel == 2'b01) || (sel == 2'b10);
  endfunction

  // Tick routed by a select code.
  function automatic logic route_tick(input logic [1:0] sel,
                                      input logic osc, input logic fix);
    logic t;
    case (sel)
      2'b01, 2'b10: t = osc;
      2'b11:        t = fix;
      default:      t = 1'b0;
    endcase
    return t;
  endfunction

  // True when a count value is the final one before a limit.
  function automatic logic at_last(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/scl_tick_src.sv
module scl_tick_src
  import scl_tg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclr,
  input  logic       load,
  input  logic       go_idle,
  input  logic [1:0] cfg_sel,
  input  logic       cfg_div,
  input  logic       osc_tick,
  input  logic       fix_tick,
  output logic       osc_mode,
  output logic       eff_tick
);

  logic [1:0] act_sel;
  logic       act_div;
  logic       half_q;
  logic       raw_tick;

  assign raw_tick = route_tick(act_sel, osc_tick, fix_tick);
  assign eff_tick = act_div ? (raw_tick & half_q) : raw_tick;
  assign osc_mode = sel_is_osc(act_sel);

  // Active configuration: taken only at a low-phase start, dropped on idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= 2'b00;
      act_div <= 1'b0;
    end else if (sclr || go_idle) begin
      act_sel <= 2'b00;
      act_div <= 1'b0;
    end else if (load) begin
      act_sel <= cfg_sel;
      act_div <= cfg_div;
    end
  end

  // Divide-by-two phase: toggles on every routed tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        half_q <= 1'b0;
    else if (sclr)     half_q <= 1'b0;
    else if (raw_tick) half_q <= ~half_q;
  end

  // R8: the active configuration moves only on a load, an idle return or a reset.
  a_r8_cfg_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sel) |-> $past(load || go_idle || sclr));

  // R5: with halving on, a passed tick is never followed by a passed tick on the next raw tick.
  a_r5_alternate_pass: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    (eff_tick && act_div && !load) |=> (raw_tick && act_div) |-> !eff_tick);

endmodule

// File: rtl/scl_tick_counter.sv
module scl_tick_counter
  import scl_tg_pkg::*;
#(
  parameter int unsigned LIMIT = 96,
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclr,
  input  logic active,
  input  logic tick,
  output logic hit
);

  logic [CNT_W-1:0] cnt_q;
  logic             reached_q;
  logic             last;

  assign last = at_last(32'(cnt_q), LIMIT);
  assign hit  = reached_q | (active & tick & last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      reached_q <= 1'b0;
    end else if (sclr || !active) begin
      cnt_q     <= '0;
      reached_q <= 1'b0;
    end else if (tick && !reached_q) begin
      if (last) reached_q <= 1'b1;
      else      cnt_q     <= cnt_q + 1'b1;
    end
  end

  // R3: the count never reaches its limit; completion is held in the sticky flag.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < int'(LIMIT));

  // R3: once complete, the count stays complete while the phase lasts.
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    (reached_q && active) |=> (reached_q || !active));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclr,
  input  logic [1:0] cfg_sel,
  input  logic       osc_mode,
  input  logic       scl_in,
  input  logic       low_hit,
  input  logic       win_hit,
  input  logic       min_hit,
  output scl_phase_e phase,
  output logic       load,
  output logic       go_idle,
  output logic       drive_low,
  output logic       fall_stb,
  output logic       rise_stb
);

  scl_phase_e nxt;
  logic       seen_high;
  logic       high_done;

  assign high_done = win_hit & (min_hit | ~osc_mode);

  always_comb begin
    nxt       = phase;
    load      = 1'b0;
    go_idle   = 1'b0;
    seen_high = 1'b0;
    unique case (phase)
      PH_IDLE: if (sel_enabled(cfg_sel)) begin
        nxt  = PH_LOW;
        load = 1'b1;
      end
      PH_LOW: if (low_hit) nxt = PH_WAIT;
      PH_WAIT: if (scl_in) begin
        nxt       = PH_HIGH;
        seen_high = 1'b1;
      end
      PH_HIGH: if (high_done) begin
        if (sel_enabled(cfg_sel)) begin
          nxt  = PH_LOW;
          load = 1'b1;
        end else begin
          nxt     = PH_IDLE;
          go_idle = 1'b1;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      drive_low <= 1'b0;
      fall_stb  <= 1'b0;
      rise_stb  <= 1'b0;
    end else if (sclr) begin
      phase     <= PH_IDLE;
      drive_low <= 1'b0;
      fall_stb  <= 1'b0;
      rise_stb  <= 1'b0;
    end else begin
      phase     <= nxt;
      drive_low <= (nxt == PH_LOW);
      fall_stb  <= load;
      rise_stb  <= seen_high;
    end
  end

  // R9: the falling strobe marks the first cycle of a pull-down.
  a_r9_fall_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (drive_low && !$past(drive_low)));

  // R9: every new pull-down carries the falling strobe.
  a_r9_every_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> fall_stb);

  // R9: the rising strobe follows a high sample of the released line.
  a_r9_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> ($past(scl_in) && !drive_low));

  // R9: strobes never coincide.
  a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb));

  // R6: while waiting on the line, the block neither drives nor marks a rise.
  a_r6_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !scl_in) |=> !rise_stb);

  // R10: a sampled software reset leaves the block idle and released.
  a_r10_held_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sclr) |-> (phase == PH_IDLE && !drive_low && !fall_stb && !rise_stb));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int unsigned HIGH_TICKS     = 96,
  parameter int unsigned LOW_TICKS      = 144,
  parameter int unsigned MIN_HIGH_TICKS = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic [1:0] src_sel,
  input  logic       div2_en,
  input  logic       osc_tick,
  input  logic       fix_tick,
  input  logic       scl_in,
  output logic       scl_drive_low,
  output logic       scl_fall_stb,
  output logic       scl_rise_stb,
  output logic       running
);

  localparam int unsigned MAX_TICKS = max3(HIGH_TICKS, LOW_TICKS, MIN_HIGH_TICKS);
  localparam int unsigned CNT_W     = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS);
  localparam int unsigned N_CNT     = 3;
  localparam int unsigned IDX_LOW   = 0;
  localparam int unsigned IDX_WIN   = 1;
  localparam int unsigned IDX_MIN   = 2;

  scl_phase_e       phase;
  logic             load;
  logic             go_idle;
  logic             osc_mode;
  logic             eff_tick;
  logic [N_CNT-1:0] cnt_active;
  logic [N_CNT-1:0] cnt_hit;

  scl_tick_src u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclr     (soft_rst),
    .load     (load),
    .go_idle  (go_idle),
    .cfg_sel  (src_sel),
    .cfg_div  (div2_en),
    .osc_tick (osc_tick),
    .fix_tick (fix_tick),
    .osc_mode (osc_mode),
    .eff_tick (eff_tick)
  );

  // Phase windows: low length, high window from release, minimum high from line-high.
  assign cnt_active[IDX_LOW] = (phase == PH_LOW);
  assign cnt_active[IDX_WIN] = (phase == PH_WAIT) || (phase == PH_HIGH);
  assign cnt_active[IDX_MIN] = (phase == PH_HIGH);

  function automatic int unsigned limit_of(input int unsigned idx);
    case (idx)
      IDX_LOW: return LOW_TICKS;
      IDX_WIN: return HIGH_TICKS;
      default: return MIN_HIGH_TICKS;
    endcase
  endfunction

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    scl_tick_counter #(
      .LIMIT (limit_of(g)),
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclr   (soft_rst),
      .active (cnt_active[g]),
      .tick   (eff_tick),
      .hit    (cnt_hit[g])
    );
  end

  scl_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclr      (soft_rst),
    .cfg_sel   (src_sel),
    .osc_mode  (osc_mode),
    .scl_in    (scl_in),
    .low_hit   (cnt_hit[IDX_LOW]),
    .win_hit   (cnt_hit[IDX_WIN]),
    .min_hit   (cnt_hit[IDX_MIN]),
    .phase     (phase),
    .load      (load),
    .go_idle   (go_idle),
    .drive_low (scl_drive_low),
    .fall_stb  (scl_fall_stb),
    .rise_stb  (scl_rise_stb)
  );

  assign running = (phase != PH_IDLE);

  // R1: an idle block never pulls the line.
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !scl_drive_low);

  // R2: with the source off and the block idle, no falling edge follows.
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sel_enabled(src_sel)) |=> !scl_fall_stb);

  // R7: an oscillator-paced high phase is not ended before its minimum.
  a_r7_min_high: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (phase == PH_HIGH && osc_mode && !cnt_hit[IDX_MIN]) |=> !scl_drive_low);

  // R3: a low phase does not end before its tick count completes.
  a_r3_low_full: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (phase == PH_LOW && !cnt_hit[IDX_LOW]) |=> scl_drive_low);

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

  localparam int LOW_T = 9;
  localparam int HIGH_T = 6;
  localparam int MIN_T = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic       div2_en = 1'b0;
  logic       osc_tick = 1'b0;
  logic       fix_tick = 1'b0;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, scl_fall_stb, scl_rise_stb, running;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  assign scl_in = ~scl_drive_low & ~stretch;

  always #5 clk = ~clk;

  scl_timing_gen #(
    .HIGH_TICKS     (HIGH_T),
    .LOW_TICKS      (LOW_T),
    .MIN_HIGH_TICKS (MIN_T)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .src_sel       (src_sel),
    .div2_en       (div2_en),
    .osc_tick      (osc_tick),
    .fix_tick      (fix_tick),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .scl_fall_stb  (scl_fall_stb),
    .scl_rise_stb  (scl_rise_stb),
    .running       (running)
  );

  // Free-running tick sources, updated just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      fix_tick = (cyc % 4 == 0);
      osc_tick = (cyc % 3 == 1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard item: one phase and the tick count expected in it.
  typedef struct {
    bit    is_low;
    bit    use_osc;
    bit    from_rise;
    int    exp;
    string tag;
  } phase_item_t;

  phase_item_t q[$];
  phase_item_t cur;
  bit  armed = 1'b0;
  bit  counting = 1'b0;
  int  tick_cnt = 0;
  logic prev_drive = 1'b0;
  logic prev_run = 1'b0;
  logic released_now;

  task automatic push(input bit is_low, input bit use_osc, input bit from_rise,
                      input int exp, input string tag);
    phase_item_t it;
    it.is_low = is_low; it.use_osc = use_osc; it.from_rise = from_rise;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: measures each armed phase in ticks of the expected source.
  always @(negedge clk) begin
    released_now = prev_drive && !scl_drive_low;
    if (armed) begin
      if (cur.is_low && released_now) begin
        check(tick_cnt == cur.exp, cur.tag, tick_cnt, cur.exp, "low-phase ticks");
        armed = 1'b0;
      end else if (!cur.is_low && (scl_fall_stb || (prev_run && !running))) begin
        check(tick_cnt == cur.exp, cur.tag, tick_cnt, cur.exp, "high-phase ticks");
        armed = 1'b0;
      end
    end
    if (!armed && q.size() > 0) begin
      if ((q[0].is_low && scl_fall_stb) || (!q[0].is_low && released_now)) begin
        cur = q.pop_front();
        armed = 1'b1;
        tick_cnt = 0;
        counting = !cur.from_rise;
      end
    end
    if (armed && scl_rise_stb) counting = 1'b1;
    if (armed && counting && (cur.use_osc ? osc_tick : fix_tick)) tick_cnt++;
    prev_drive = scl_drive_low;
    prev_run = running;
  end

  task automatic wait_fall(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (!scl_fall_stb && n < 3000);
    if (!scl_fall_stb) check(1'b0, req, 0, 1, "falling strobe timeout");
  endtask

  task automatic wait_rise(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (!scl_rise_stb && n < 3000);
    if (!scl_rise_stb) check(1'b0, req, 0, 1, "rising strobe timeout");
  endtask

  task automatic wait_release(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (scl_drive_low && n < 3000);
    if (scl_drive_low) check(1'b0, req, 1, 0, "release timeout");
  endtask

  task automatic wait_empty(input string req);
    int n = 0;
    while ((q.size() > 0 || armed) && n < 5000) begin @(negedge clk); n++; end
    check(q.size() == 0 && !armed, req, q.size(), 0, "scoreboard drained");
  endtask

  task automatic quiet_window(input int len, input string req);
    int strobes = 0;
    int drives = 0;
    int runs = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      strobes += int'(scl_fall_stb) + int'(scl_rise_stb);
      drives += int'(scl_drive_low);
      runs += int'(running);
    end
    check(strobes == 0, req, strobes, 0, "strobes in quiet window");
    check(drives == 0, req, drives, 0, "pull-down cycles in quiet window");
    check(runs == 0, req, runs, 0, "running cycles in quiet window");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!scl_drive_low, "R1", scl_drive_low, 0, "drive after reset");
    check(!running, "R1", running, 0, "running after reset");
    check(!scl_fall_stb && !scl_rise_stb, "R1", scl_fall_stb | scl_rise_stb, 0, "strobes after reset");

    // R2: source off
    quiet_window(100, "R2");

    // R3: fixed source, undivided
    src_sel = 2'b11;
    wait_fall("R3");
    wait_rise("R3");
    push(1, 0, 0, LOW_T, "R3");
    push(0, 0, 0, HIGH_T, "R3");
    push(1, 0, 0, LOW_T, "R3");
    push(0, 0, 0, HIGH_T, "R3");
    wait_empty("R3");

    // R5: halved ticks in steady state
    div2_en = 1'b1;
    wait_fall("R5");
    wait_fall("R5");
    wait_rise("R5");
    push(1, 0, 0, 2 * LOW_T, "R5");
    push(0, 0, 0, 2 * HIGH_T, "R5");
    push(1, 0, 0, 2 * LOW_T, "R5");
    push(0, 0, 0, 2 * HIGH_T, "R5");
    wait_empty("R5");
    div2_en = 1'b0;

    // R4: oscillator source, both codes
    src_sel = 2'b01;
    wait_fall("R4");
    wait_fall("R4");
    wait_rise("R4");
    push(1, 1, 0, LOW_T, "R4");
    push(0, 1, 0, HIGH_T, "R4");
    wait_empty("R4");
    src_sel = 2'b10;
    wait_fall("R4");
    wait_fall("R4");
    wait_rise("R4");
    push(1, 1, 0, LOW_T, "R4");
    push(0, 1, 0, HIGH_T, "R4");
    wait_empty("R4");

    // R8: select change during a low phase takes effect one low phase later
    wait_rise("R8");
    push(1, 1, 0, LOW_T, "R8");
    push(0, 1, 0, HIGH_T, "R8");
    push(1, 0, 0, LOW_T, "R8");
    push(0, 0, 0, HIGH_T, "R8");
    wait_fall("R8");
    repeat (5) @(negedge clk);
    src_sel = 2'b11;
    wait_empty("R8");

    // R6: short stretch does not lengthen the high window
    wait_fall("R6");
    stretch = 1'b1;
    push(0, 0, 0, HIGH_T, "R6");
    wait_release("R6");
    repeat (8) @(negedge clk);
    stretch = 1'b0;
    wait_empty("R6");

    // R6/R7: long stretch with the oscillator source
    src_sel = 2'b01;
    wait_fall("R7");
    wait_fall("R7");
    stretch = 1'b1;
    push(0, 1, 1, MIN_T, "R7");
    wait_release("R6");
    begin
      int rises = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        rises += int'(scl_rise_stb);
      end
      check(rises == 0, "R6", rises, 0, "rising strobes while held low");
      check(running, "R6", running, 1, "running while held low");
    end
    stretch = 1'b0;
    @(negedge clk);
    check(scl_rise_stb, "R9", scl_rise_stb, 1, "rising strobe one cycle after line high");
    wait_empty("R7");

    // R7: fixed source, no minimum after a long stretch
    src_sel = 2'b11;
    wait_fall("R7");
    wait_fall("R7");
    stretch = 1'b1;
    wait_release("R7");
    repeat (40) @(negedge clk);
    stretch = 1'b0;
    @(negedge clk);
    check(scl_rise_stb, "R9", scl_rise_stb, 1, "rising strobe after stretch");
    @(negedge clk);
    check(scl_fall_stb, "R7", scl_fall_stb, 1, "fall right after rise, fixed source");
    check(scl_drive_low, "R9", scl_drive_low, 1, "drive with falling strobe");

    // R8: select off finishes the high phase, then idles
    wait_fall("R8");
    push(0, 0, 0, HIGH_T, "R8");
    src_sel = 2'b00;
    wait_empty("R8");
    check(!running, "R8", running, 0, "running after select off");
    check(!scl_drive_low, "R8", scl_drive_low, 0, "line released after select off");
    quiet_window(100, "R2");

    // R10 and R5: held software reset, then deterministic divider phase
    src_sel = 2'b11;
    div2_en = 1'b1;
    wait_fall("R10");
    repeat (10) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    check(!scl_drive_low, "R10", scl_drive_low, 0, "drive under software reset");
    check(!running, "R10", running, 0, "running under software reset");
    quiet_window(50, "R10");
    push(1, 0, 0, 2 * LOW_T, "R5");
    soft_rst = 1'b0;
    @(negedge clk);
    check(scl_fall_stb, "R10", scl_fall_stb, 1, "restart after software reset");
    wait_empty("R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule